// File: doc/BRIEF.md
# DAC Double-Buffered Update Controller

This block sits between an 8-bit register write port and the input latch of a 12-bit digital-to-analog converter. Software writes a low data byte and a high data byte into two staging registers, and a control register sets two things: when the staged value is committed to the converter latch, and how the 12-bit code is positioned inside the 16-bit staging pair.

There are two kinds of commit. In the immediate mode, writing the high byte commits the pair at once. This also allows 8-bit operation: the low byte is loaded once, and each later update is a single high-byte write. In the three scheduled modes, data writes only fill the staging registers. The commit happens when the chosen timer overflow strobe arrives. Because the commit is tied to a timer and not to the moment software writes, waveform samples come out at a fixed rate and are not affected by interrupt latency.

Each time the latch is loaded, the block raises a one-cycle pulse.

Top module: `dac_update_ctrl`

## Requirements
- R1: After synchronous reset, `dac_code` is 0 and `dac_load` is 0. Both staging bytes are 0, and the mode and format fields are 0.
- R2: The write address selects the register: 0 is the low byte, 1 is the high byte, 2 is control, and 3 is ignored. In control, bits [4:3] are the mode and bits [2:0] are the format; bits [7:5] are ignored.
- R3: In mode 0, a high-byte write loads the latch with {written byte, low byte}, justified by the current format. The value appears on `dac_code` one cycle after the write.
- R4: In mode 0, a low-byte write is only stored. The latch does not change until a later high-byte write.
- R5: 8-bit use works. After the low byte is preloaded once, every high-byte write on its own (including back-to-back writes) produces a fresh commit.
- R6: In modes 1, 2 and 3, data writes are only stored. The latch loads {high, low} when the selected overflow strobe is 1: `tmr_ovf[0]` for mode 1, `tmr_ovf[1]` for mode 2, and `tmr_ovf[2]` for mode 3.
- R7: In modes 1 to 3, the two unselected strobes have no effect. In mode 0, all three strobes have no effect.
- R8: The format sets where the code is taken from the 16-bit pair P. Format 0 takes P[11:0], 1 takes P[12:1], 2 takes P[13:2], 3 takes P[14:3], and 4 takes P[15:4]. Formats 5 to 7 act as 4.
- R9: The format in force in the cycle of the commit is the one applied. A format changed after the data was staged still takes effect.
- R10: If the selected overflow and a data write fall in the same cycle, the latch takes the pair as it was before the write, and the write still reaches the staging register.
- R11: `dac_load` is high for exactly one cycle for each commit. `dac_code` changes only in the cycles where `dac_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 low, 1 high, 2 control, 3 none |
| wr_data | input | 8 | Write data byte |
| tmr_ovf | input | 3 | Timer overflow strobes, one cycle each |
| dac_code | output | 12 | Converter input latch |
| dac_load | output | 1 | One-cycle pulse when the latch is loaded |

## Verification
The assertions assume that the inputs are synchronous to `clk` and that each overflow strobe is a single-cycle level sampled at the edge. They also assume that at most one register write occurs per cycle, which is what the port can express. The stimulus drives every input on the falling edge, in separate steps, and holds each strobe high for one step only. Collisions are created on purpose by putting a write and an overflow in the same step. The scoreboard predicts each commit from a model of the staging registers that is updated in program order.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_CTL  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int FMT_W = 3;
endpackage

// File: rtl/dac_stage_regs.sv
module dac_stage_regs
  import dac_upd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [FMT_W-1:0]  fmt_q
);
  localparam int MODE_LSB = FMT_W;
  localparam int MODE_MSB = FMT_W + MODE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
      fmt_q  <= '0;
    end else if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        ADDR_LO:  lo_q <= wr_data;
        ADDR_HI:  hi_q <= wr_data;
        ADDR_CTL: begin
          mode_q <= wr_data[MODE_MSB:MODE_LSB];
          fmt_q  <= wr_data[FMT_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_trigger.sv
module dac_trigger #(
  parameter int NUM_TMR = 3,
  parameter int MODE_W  = 2
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic               hi_wr,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  output logic               commit,
  output logic               use_bus
);
  logic [NUM_TMR-1:0] tmr_hit;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign tmr_hit[i] = tmr_ovf[i] && (mode == MODE_W'(i + 1));
  end

  assign use_bus = hi_wr && (mode == '0);
  assign commit  = use_bus || (|tmr_hit);
endmodule

// File: rtl/dac_justify.sv
module dac_justify #(
  parameter int PAIR_W = 16,
  parameter int DATA_W = 12,
  parameter int FMT_W  = 3
) (
  input  logic [PAIR_W-1:0] pair,
  input  logic [FMT_W-1:0]  fmt,
  output logic [DATA_W-1:0] code
);
  localparam int SHIFT_MAX = PAIR_W - DATA_W;

  logic [DATA_W-1:0] cand [SHIFT_MAX+1];

  for (genvar s = 0; s <= SHIFT_MAX; s++) begin : g_cand
    assign cand[s] = pair[s+DATA_W-1:s];
  end

  always_comb begin
    code = cand[SHIFT_MAX];
    for (int s = 0; s < SHIFT_MAX; s++) begin
      if (int'(fmt) == s) code = cand[s];
    end
  end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_upd_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int DATA_W  = 12,
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  output logic [DATA_W-1:0]  dac_code,
  output logic               dac_load
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int MODE_W = $clog2(NUM_TMR + 1);

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [MODE_W-1:0] mode_q;
  logic [FMT_W-1:0]  fmt_q;
  logic              hi_wr, commit, use_bus;
  logic [PAIR_W-1:0] pair_src;
  logic [DATA_W-1:0] code_next;

  assign hi_wr = wr_en && (reg_addr_e'(wr_addr) == ADDR_HI);

  dac_stage_regs #(.BYTE_W(BYTE_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lo_q(lo_q), .hi_q(hi_q),
    .mode_q(mode_q), .fmt_q(fmt_q)
  );

  dac_trigger #(.NUM_TMR(NUM_TMR), .MODE_W(MODE_W)) u_trig (
    .mode(mode_q), .hi_wr(hi_wr), .tmr_ovf(tmr_ovf),
    .commit(commit), .use_bus(use_bus)
  );

  // Immediate mode takes the byte on the bus; timer modes take the stored pair.
  assign pair_src = use_bus ? {wr_data, lo_q} : {hi_q, lo_q};

  dac_justify #(.PAIR_W(PAIR_W), .DATA_W(DATA_W), .FMT_W(FMT_W)) u_just (
    .pair(pair_src), .fmt(fmt_q), .code(code_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0;
      dac_load <= 1'b0;
    end else begin
      dac_load <= commit;
      if (commit) dac_code <= code_next;
    end
  end

  assert_hiwr_loads_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == '0 && hi_wr) |=> dac_load);

  assert_nohi_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == '0 && !hi_wr) |=> !dac_load);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    assert_sel_tmr_loads_R6: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_W'(i + 1) && tmr_ovf[i]) |=> dac_load);
    assert_unsel_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_W'(i + 1) && !tmr_ovf[i]) |=> !dac_load);
  end

  assert_code_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !dac_load |-> $stable(dac_code));
endmodule

// File: tb/tb_dac_update_ctrl.sv
module tb_dac_update_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [2:0]  tmr_ovf = 3'd0;
  logic [11:0] dac_code;
  logic        dac_load;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]  m_lo = 0, m_hi = 0;
  logic [1:0]  m_mode = 0;
  logic [2:0]  m_fmt = 0;
  logic [11:0] m_code = 0;
  logic [11:0] exp_q [$];
  string       req_q [$];

  always #2.5 clk = ~clk;

  dac_update_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmr_ovf(tmr_ovf),
    .dac_code(dac_code), .dac_load(dac_load)
  );

  function automatic logic [11:0] justify(logic [15:0] p, logic [2:0] f);
    case (f)
      3'd0:    return p[11:0];
      3'd1:    return p[12:1];
      3'd2:    return p[13:2];
      3'd3:    return p[14:3];
      default: return p[15:4];
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: one step per falling edge; predicts commits into the scoreboard.
  task automatic step(input bit we, input logic [1:0] a, input logic [7:0] d,
                      input logic [2:0] t, input string req);
    bit trig;
    logic [15:0] p;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tmr_ovf = t;
    if (m_mode == 2'd0) begin
      trig = we && a == 2'd1;
      p = {d, m_lo};
    end else begin
      trig = t[m_mode - 1];
      p = {m_hi, m_lo};
    end
    if (trig) begin
      exp_q.push_back(justify(p, m_fmt));
      req_q.push_back(req);
    end
    if (we) begin
      case (a)
        2'd0: m_lo = d;
        2'd1: m_hi = d;
        2'd2: begin m_mode = d[4:3]; m_fmt = d[2:0]; end
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'd0, 3'd0, "idle");
  endtask

  // Monitor: samples 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      if (dac_load) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected load", dac_code, m_code);
        end else begin
          logic [11:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(dac_code == e, r, dac_code, e);
          m_code = e;
        end
      end else begin
        if (exp_q.size() != 0) begin
          string r;
          r = req_q.pop_front();
          chk(1'b0, {r, " missing load"}, 0, exp_q.pop_front());
        end
        if (dac_code != m_code) chk(1'b0, "R11 code moved without load", dac_code, m_code);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_code == 12'd0, "R1 code after reset", dac_code, 0);
    chk(dac_load == 1'b0, "R1 load after reset", dac_load, 0);
    // R1: staging is zero; a timer-mode commit with no data writes gives 0
    step(1'b1, 2'd2, 8'h08, 3'd0, "R1");
    step(1'b0, 2'd0, 8'h00, 3'b001, "R1 staged zero");
    step(1'b1, 2'd2, 8'h00, 3'd0, "R2");
    // R4: a low-byte write alone does not commit
    step(1'b1, 2'd0, 8'h34, 3'd0, "R4");
    idle(2);
    chk(dac_code == 12'd0, "R4 low write held", dac_code, 0);
    // R3: a high-byte write commits
    step(1'b1, 2'd1, 8'hAB, 3'd0, "R3 high write commit");
    idle(2);
    // R7: strobes ignored in mode 0
    step(1'b0, 2'd0, 8'h00, 3'b111, "R7 mode0 strobes");
    idle(2);
    chk(dac_code == 12'hB34, "R7 mode0 strobes ignored", dac_code, 12'hB34);
    // R2: address 3 is ignored, and control bits [7:5] are ignored
    step(1'b1, 2'd3, 8'h77, 3'd0, "R2");
    step(1'b1, 2'd2, 8'hE8, 3'd0, "R2");
    step(1'b0, 2'd0, 8'h00, 3'b001, "R2 addr3 ignored, mode from bits 4:3");
    idle(2);
    // R5: 8-bit use, left-justified format
    step(1'b1, 2'd2, 8'h04, 3'd0, "R5");
    step(1'b1, 2'd0, 8'h00, 3'd0, "R5");
    step(1'b1, 2'd1, 8'h12, 3'd0, "R5 8-bit update a");
    step(1'b1, 2'd1, 8'h80, 3'd0, "R5 8-bit update b");
    step(1'b1, 2'd1, 8'hFF, 3'd0, "R5 8-bit update c");
    idle(2);
    // R8: every format code
    step(1'b1, 2'd0, 8'h3A, 3'd0, "R8");
    for (int f = 0; f < 8; f++) begin
      step(1'b1, 2'd2, 8'(f), 3'd0, "R8");
      step(1'b1, 2'd1, 8'hC5, 3'd0, "R8 format");
    end
    idle(2);
    // R6: each timer mode and the strobe it selects
    for (int m = 1; m < 4; m++) begin
      step(1'b1, 2'd2, 8'(m << 3), 3'd0, "R6");
      step(1'b1, 2'd0, 8'(8'h10 * m + 1), 3'd0, "R6");
      step(1'b1, 2'd1, 8'(8'h0F - m), 3'd0, "R6");
      idle(1);
      chk(dac_load == 1'b0, "R6 writes held in timer mode", dac_load, 0);
      // R7: the unselected strobes only
      step(1'b0, 2'd0, 8'h00, 3'b111 & ~(3'b001 << (m - 1)), "R7 unselected");
      idle(1);
      step(1'b0, 2'd0, 8'h00, 3'b001 << (m - 1), "R6 selected overflow");
      idle(1);
    end
    // R9: format changed after staging is still applied
    step(1'b1, 2'd2, 8'h08, 3'd0, "R9");
    step(1'b1, 2'd0, 8'h5C, 3'd0, "R9");
    step(1'b1, 2'd1, 8'hA7, 3'd0, "R9");
    step(1'b1, 2'd2, 8'h0C, 3'd0, "R9");
    step(1'b0, 2'd0, 8'h00, 3'b001, "R9 format at commit");
    idle(1);
    // R10: write and selected overflow in the same cycle
    step(1'b1, 2'd1, 8'h3E, 3'b001, "R10 collision old pair");
    step(1'b0, 2'd0, 8'h00, 3'b001, "R10 new high landed");
    step(1'b1, 2'd0, 8'h99, 3'b001, "R10 collision low");
    step(1'b0, 2'd0, 8'h00, 3'b001, "R10 new low landed");
    idle(3);
    chk(exp_q.size() == 0, "R11 all commits seen", exp_q.size(), 0);
    finish_run();
  end
endmodule